// File: doc/BRIEF.md
# Predicate-Result Condition Test Unit

This block decides, one vector element at a time, what happens to an element whose result has already been computed. It works out a 4-bit condition field from the signed result (less-than, greater-than, equal, summary-overflow). It then applies a branch-style test to one bit of that field. A failed test acts like an extra predicate bit that cancels the destination write. The condition field itself can still be recorded, so software can later see which elements failed.

The unit is purely combinational. Its enables are valid in the same cycle as the element strobe, so it can sit directly between an execution unit and the register-file write ports. A zeroing mode turns skipped elements into writes of zero instead of leaving them untouched. A compare-only mode keeps the condition field and throws the result away.

Internally the unit sorts every element into one of five dispositions:
- IDLE: no element is presented.
- SKIP: the element is masked or dropped, and nothing is written.
- ZERO: the destination receives zero.
- WRITE: the result is stored.
- DROP: the result is discarded because the element is compare-only.

A disposition is chosen from the strobe, the predicate, the compare-only flag, the test outcome and the zeroing bit, in that priority order.

Top module: `pred_result_unit`

## Requirements
- R1: While `elem_valid` is low, `res_we`, `res_zero` and `cr_we` are all low.
- R2: `cr_field` = {lt, gt, eq, so} with lt at bit 3, gt at bit 2, eq at bit 1 and so at bit 0. The result is read as a signed two's-complement value of `DATA_W` bits: eq is set for zero, gt for positive and lt for negative, and exactly one of the three is set.
- R3: Bit 0 of `cr_field` (summary-overflow) equals `so_in`.
- R4: A valid element with `elem_pred` low never writes the condition field. Its result write happens only when `zero_en` is high, and then it is a forced zero (`res_we` = `res_zero` = `zero_en`).
- R5: For a valid element with `elem_pred` high, `cr_we` is high exactly when `rec_en` or `cmp_only` is high, whatever the test outcome.
- R6: `test_sel` picks the tested bit as bit (3 − `test_sel`) of `cr_field`: 0 = lt, 1 = gt, 2 = eq, 3 = so. The test passes when that bit equals `test_want`. A passing, predicated, non-compare-only element gives `res_we`=1 and `res_zero`=0.
- R7: A predicated, non-compare-only element that fails the test writes zero when `zero_en` is high (`res_we`=`res_zero`=1). Otherwise it writes nothing.
- R8: When `cmp_only` is high, `res_we` and `res_zero` are low, even with `zero_en` high and a failed test.
- R9: `res_zero` is never high without `res_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| elem_valid | input | 1 | An element is presented this cycle |
| elem_value | input | DATA_W | Computed element result |
| elem_pred | input | 1 | Element predicate bit |
| rec_en | input | 1 | Record the condition field |
| cmp_only | input | 1 | Compare-only: store only the condition field |
| zero_en | input | 1 | Zeroing of masked or failed elements |
| test_sel | input | 2 | Index of the condition bit under test |
| test_want | input | 1 | Expected value of the tested bit |
| so_in | input | 1 | Summary-overflow flag copied into the field |
| res_we | output | 1 | Destination result write enable |
| res_zero | output | 1 | Write zero instead of the result |
| cr_we | output | 1 | Condition field write enable |
| cr_field | output | 4 | Derived condition field {lt,gt,eq,so} |

## Verification
The assertions check the following on every evaluation:
- the idle state;
- the one-hot sign classification and the summary-overflow copy;
- the masked-element rule;
- the compare-only suppression;
- the rule that zero implies a write.

Only the bench's scenarios can show that the tested bit is the one `test_sel` names, and that pass or fail routes correctly to write or zero. It also shows the exact boundaries of the sign test at zero, at −1 and at the extreme signed values. These are checked against an independent reference function driven by both seeded random stimulus and directed corner cases.

// File: rtl/prt_pkg.sv
package prt_pkg;

    // Condition field layout; the test index decodes against this order.
    localparam int CF_W  = 4;
    localparam int CF_LT = 3;
    localparam int CF_GT = 2;
    localparam int CF_EQ = 1;
    localparam int CF_SO = 0;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    typedef enum logic [2:0] {
        DISP_IDLE,
        DISP_SKIP,
        DISP_ZERO,
        DISP_WRITE,
        DISP_DROP
    } disp_t;

endpackage

// File: rtl/prt_cond_gen.sv
module prt_cond_gen
    import prt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] value,
    input  logic              so_in,
    output cond_t             cond
);
    localparam int SIGN_BIT = DATA_W - 1;

    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero  = (value == '0);
        is_neg   = value[SIGN_BIT];
        cond.lt  = is_neg;
        cond.eq  = is_zero;
        cond.gt  = !is_neg && !is_zero;
        cond.so  = so_in;
    end
endmodule

// File: rtl/prt_cond_test.sv
module prt_cond_test
    import prt_pkg::*;
(
    input  cond_t      cond,
    input  logic [1:0] sel,
    input  logic       want,
    output logic       pass
);
    logic [CF_W-1:0] flat;
    logic            picked;

    always_comb begin
        flat = cond;
        unique case (sel)
            2'd0: picked = flat[CF_LT];
            2'd1: picked = flat[CF_GT];
            2'd2: picked = flat[CF_EQ];
            2'd3: picked = flat[CF_SO];
            default: picked = 1'b0;
        endcase
        pass = (picked == want);
    end
endmodule

// File: rtl/prt_write_ctrl.sv
module prt_write_ctrl
    import prt_pkg::*;
(
    input  logic valid,
    input  logic pred,
    input  logic rec,
    input  logic cmp_only,
    input  logic zero_en,
    input  logic pass,
    output logic res_we,
    output logic res_zero,
    output logic cr_we
);
    disp_t disp;

    // Disposition selection, in priority order.
    always_comb begin
        if (!valid)
            disp = DISP_IDLE;
        else if (!pred)
            disp = zero_en ? DISP_ZERO : DISP_SKIP;
        else if (cmp_only)
            disp = DISP_DROP;
        else if (pass)
            disp = DISP_WRITE;
        else
            disp = zero_en ? DISP_ZERO : DISP_SKIP;
    end

    // Output decode per disposition.
    always_comb begin
        res_we   = 1'b0;
        res_zero = 1'b0;
        unique case (disp)
            DISP_IDLE:  ;
            DISP_SKIP:  ;
            DISP_DROP:  ;
            DISP_WRITE: res_we = 1'b1;
            DISP_ZERO: begin
                res_we   = 1'b1;
                res_zero = 1'b1;
            end
            default: ;
        endcase
        cr_we = valid && pred && (rec || cmp_only);
    end
endmodule

// File: rtl/pred_result_unit.sv
module pred_result_unit
    import prt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              elem_valid,
    input  logic [DATA_W-1:0] elem_value,
    input  logic              elem_pred,
    input  logic              rec_en,
    input  logic              cmp_only,
    input  logic              zero_en,
    input  logic [1:0]        test_sel,
    input  logic              test_want,
    input  logic              so_in,
    output logic              res_we,
    output logic              res_zero,
    output logic              cr_we,
    output logic [CF_W-1:0]   cr_field
);
    cond_t cond;
    logic  pass;

    prt_cond_gen #(.DATA_W(DATA_W)) u_gen (
        .value (elem_value),
        .so_in (so_in),
        .cond  (cond)
    );

    prt_cond_test u_test (
        .cond (cond),
        .sel  (test_sel),
        .want (test_want),
        .pass (pass)
    );

    prt_write_ctrl u_ctrl (
        .valid    (elem_valid),
        .pred     (elem_pred),
        .rec      (rec_en),
        .cmp_only (cmp_only),
        .zero_en  (zero_en),
        .pass     (pass),
        .res_we   (res_we),
        .res_zero (res_zero),
        .cr_we    (cr_we)
    );

    assign cr_field = cond;
endmodule

// File: rtl/pred_result_chk.sv
module pred_result_chk #(
    parameter int DATA_W = 64
) (
    input logic              elem_valid,
    input logic [DATA_W-1:0] elem_value,
    input logic              elem_pred,
    input logic              cmp_only,
    input logic              zero_en,
    input logic              so_in,
    input logic              res_we,
    input logic              res_zero,
    input logic              cr_we,
    input logic [3:0]        cr_field
);
    always_comb begin
        if (!elem_valid) begin
            a_r1_idle_quiet: assert (!res_we && !res_zero && !cr_we);
        end
        a_r2_one_class: assert ($countones(cr_field[3:1]) == 1);
        a_r2_zero_is_eq: assert ((elem_value == '0) == cr_field[1]);
        a_r3_so_copy: assert (cr_field[0] == so_in);
        if (elem_valid && !elem_pred) begin
            a_r4_masked_no_cr: assert (!cr_we);
            a_r4_masked_zero: assert (res_we == zero_en && res_zero == zero_en);
        end
        if (elem_valid && elem_pred && cmp_only) begin
            a_r8_cmp_no_result: assert (!res_we && !res_zero && cr_we);
        end
        a_r9_zero_implies_we: assert (!res_zero || res_we);
    end
endmodule

bind pred_result_unit pred_result_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_pred_result_unit.sv
module test_pred_result_unit;
    localparam int  DATA_W = 64;
    localparam time CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              elem_valid, elem_pred, rec_en, cmp_only, zero_en, test_want, so_in;
    logic [DATA_W-1:0] elem_value;
    logic [1:0]        test_sel;
    logic              res_we, res_zero, cr_we;
    logic [3:0]        cr_field;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_result_unit #(.DATA_W(DATA_W)) i_pred_result_unit (.*);

    function automatic logic [3:0] ref_cf(logic [DATA_W-1:0] v, logic so);
        logic neg = v[DATA_W-1];
        logic z   = (v == '0);
        return {neg, !neg && !z, z, so};
    endfunction

    // {res_we, res_zero, cr_we}
    function automatic logic [2:0] ref_en(logic v, logic p, logic r, logic c,
                                          logic z, logic [1:0] s, logic w,
                                          logic [3:0] cf);
        logic ok;
        if (!v) return 3'b000;
        if (!p) return {z, z, 1'b0};
        ok = (cf[3 - s] == w);
        if (c) return 3'b001;
        if (ok) return {2'b10, r};
        return {z, z, r};
    endfunction

    task automatic apply(input logic v, input logic [DATA_W-1:0] val, input logic p,
                         input logic r, input logic c, input logic z,
                         input logic [1:0] s, input logic w, input logic so,
                         input string tag);
        logic [3:0] ecf;
        logic [2:0] een;
        @(negedge clk);
        elem_valid = v; elem_value = val; elem_pred = p; rec_en = r;
        cmp_only = c; zero_en = z; test_sel = s; test_want = w; so_in = so;
        #1;
        ecf = ref_cf(val, so);
        een = ref_en(v, p, r, c, z, s, w, ecf);
        n_run++;
        if (cr_field !== ecf) begin
            n_fail++;
            $display("FAIL %s cr_field actual=%b expected=%b", tag, cr_field, ecf);
        end
        n_run++;
        if ({res_we, res_zero, cr_we} !== een) begin
            n_fail++;
            $display("FAIL %s {res_we,res_zero,cr_we} actual=%b expected=%b",
                     tag, {res_we, res_zero, cr_we}, een);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        // idle state, R1
        apply(0, 64'd5, 1, 1, 0, 1, 2'd0, 0, 0, "R1 idle");
        apply(0, 64'd0, 0, 0, 1, 1, 2'd2, 1, 1, "R1 idle2");
        // sign boundaries, R2 / R3
        apply(1, 64'd0, 1, 1, 0, 0, 2'd2, 1, 0, "R2 zero eq pass");
        apply(1, {1'b0, {(DATA_W-1){1'b1}}}, 1, 1, 0, 0, 2'd1, 1, 1, "R2 max positive R3");
        apply(1, {1'b1, {(DATA_W-1){1'b0}}}, 1, 1, 0, 0, 2'd0, 1, 0, "R2 min negative");
        apply(1, '1, 1, 0, 0, 0, 2'd0, 1, 1, "R2 minus one");
        apply(1, 64'd1, 1, 0, 0, 0, 2'd1, 1, 0, "R2 plus one");
        // masked, R4
        apply(1, 64'd7, 0, 1, 0, 0, 2'd1, 1, 0, "R4 masked no zero");
        apply(1, 64'd7, 0, 1, 1, 1, 2'd1, 1, 0, "R4 masked zeroing");
        // record independent of outcome, R5
        apply(1, 64'd3, 1, 1, 0, 0, 2'd0, 1, 0, "R5 record on fail");
        apply(1, 64'd3, 1, 0, 0, 0, 2'd1, 1, 0, "R5 no record on pass");
        // each test index, R6 / R7
        apply(1, 64'd0, 1, 0, 0, 1, 2'd3, 1, 1, "R6 so index pass");
        apply(1, 64'd0, 1, 0, 0, 1, 2'd3, 1, 0, "R7 so index fail zeroed");
        apply(1, 64'd9, 1, 0, 0, 0, 2'd2, 1, 0, "R7 eq fail dropped");
        apply(1, 64'd9, 1, 0, 0, 0, 2'd2, 0, 0, "R6 eq want0 pass");
        // compare-only, R8 / R9
        apply(1, 64'd9, 1, 0, 1, 1, 2'd2, 1, 0, "R8 cmp fail with zeroing");
        apply(1, 64'd9, 1, 0, 1, 0, 2'd1, 1, 0, "R8 cmp pass");
        // seeded random mix, all requirements R1..R9 via reference
        for (int i = 0; i < 2000; i++) begin
            logic [DATA_W-1:0] v;
            logic [3:0] k = 4'($urandom());
            v = {32'($urandom()), 32'($urandom())};
            if (k == 0) v = '0;
            else if (k == 1) v = '1;
            apply(($urandom() % 8) != 0, v, 1'($urandom()), 1'($urandom()),
                  ($urandom() % 4) == 0, 1'($urandom()), 2'($urandom()),
                  1'($urandom()), 1'($urandom()), "R9 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule